// File: doc/BRIEF.md
# CAN Controller Register Access Guard

This block sits on the CPU side of a CAN controller. It sits between a simple word-wide register bus and the controller's register file and message RAM. Every request carries a word address, a read/write flag, write data and the CPU privilege level. The block classifies the addressed word against the current configuration and decides whether the access completes or ends in an access error. The configuration is the low-power flag, the highest enabled mailbox index, the individual-mask enable and a read-only bit mask for every register word.

Legal accesses reach a small register file and a RAM model that holds the mailbox words and the individual mask words. The response comes back one clock after the request. It carries an error flag, the read data and a region class that tells the CPU how the word was decoded. Mailbox and mask words that the configuration does not use are classed as general-purpose RAM. An access that errors leaves all state alone. The protocol engine, arbitration and interrupts belong elsewhere.

Top module: `can_acc_guard`

## Requirements
- R1: Every cycle with `req_valid_i` high produces `rsp_valid_o` high exactly one clock later. A cycle without a request produces `rsp_valid_o` low one clock later. `rsp_valid_o`, `rsp_err_o` and `rsp_rdata_o` are zero after reset.
- R2: Word addresses 0x00-0x0F (byte offsets 0x000-0x03F) are registers with class 0. A read returns the stored word. A write changes only the bits b of word w whose `ro_mask_i[32*w+b]` is 0.
- R3: Register words 0x00-0x03 (byte offsets 0x000-0x00F) are supervisor-only. Any read or write to them with `req_user_i`=1 returns an error and changes nothing.
- R4: A write to a register word whose 32 read-only mask bits are all set returns an error and leaves the word unchanged. If at least one bit of the word is writable, the write succeeds with no error.
- R5: These byte ranges are reserved, give class 4 and always return an error: 0x040-0x07F, 0x180-0x87F and 0x8C0-0x9DF.
- R6: Byte offsets 0x9E0 and above are unimplemented. They give class 5 and always return an error.
- R7: While `lpm_i`=1, any access to a RAM word (byte offsets 0x080-0x17F and 0x880-0x8BF) returns an error. Register accesses do not depend on `lpm_i`.
- R8: Byte offsets 0x080-0x17F hold 16 mailboxes of 16 bytes each. A word of mailbox n gets class 1 when n <= `max_mb_i`, and class 3 (general-purpose RAM) otherwise. Either class reads and writes without error outside low power.
- R9: Byte offsets 0x880-0x8BF hold 16 four-byte mask words. Mask word k gets class 2 when `irmq_i`=1 and k <= `max_mb_i`, and class 3 otherwise. Neither class gives an error outside low power.
- R10: An access that errors changes no register or RAM word and returns `rsp_rdata_o`=0. Write responses also return zero data. A successful RAM write is returned by a later read of the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_waddr_i | input | 10 | Word address (byte offset / 4) |
| req_wdata_i | input | 32 | Write data |
| req_user_i | input | 1 | 1 = user mode, 0 = supervisor |
| lpm_i | input | 1 | Low-power mode |
| max_mb_i | input | 4 | Highest enabled mailbox index |
| irmq_i | input | 1 | Individual masking enabled |
| ro_mask_i | input | 512 | Read-only bits, 32 per register word |
| rsp_valid_o | output | 1 | Response present |
| rsp_err_o | output | 1 | Access error |
| rsp_rdata_o | output | 32 | Read data, zero on error or write |
| rsp_class_o | output | 3 | Region class: 0 reg, 1 mailbox, 2 mask, 3 free RAM, 4 reserved, 5 unimplemented |

## Verification
The bench builds the block with its default parameters: 16 mailboxes, 16 register words of which 4 are supervisor-only, and a 10-bit word address. At that size all 1024 word addresses can be swept. The sweep runs under every combination of low-power flag, mask enable, privilege level and four mailbox limits (0, 1, 7, 15). It therefore reaches each region boundary and each edge between mailbox and free RAM, and between mask and free RAM. Directed writes cover the partial and full read-only masks, a denied supervisor write and a low-power write. Each of them is followed by a read-back of the same word.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;

  typedef enum logic [2:0] {
    CLS_REG   = 3'd0,
    CLS_MB    = 3'd1,
    CLS_MASK  = 3'd2,
    CLS_GPRAM = 3'd3,
    CLS_RSVD  = 3'd4,
    CLS_UNIMP = 3'd5
  } acc_class_e;

  // word-address layout of the controller window
  localparam int MB_BASE_WORD   = 'h020;
  localparam int WORDS_PER_MB   = 4;
  localparam int MASK_BASE_WORD = 'h220;
  localparam int IMPL_END_WORD  = 'h278;
  localparam int DATA_W         = 32;

endpackage

// File: rtl/can_acc_decode.sv
module can_acc_decode
  import can_acc_pkg::*;
#(
  parameter int WA_W       = 10,
  parameter int NUM_MB     = 16,
  parameter int REG_WORDS  = 16,
  parameter int SUPV_WORDS = 4,
  localparam int MB_IDX_W  = $clog2(NUM_MB),
  localparam int REG_IDX_W = $clog2(REG_WORDS),
  localparam int RAM_WORDS = NUM_MB * (WORDS_PER_MB + 1),
  localparam int RAM_IDX_W = $clog2(RAM_WORDS)
) (
  input  logic [WA_W-1:0]             waddr_i,
  input  logic                        write_i,
  input  logic                        user_i,
  input  logic                        lpm_i,
  input  logic                        irmq_i,
  input  logic [MB_IDX_W-1:0]         max_mb_i,
  input  logic [REG_WORDS*DATA_W-1:0] ro_mask_i,
  output acc_class_e                  cls_o,
  output logic                        err_o,
  output logic                        is_reg_o,
  output logic                        is_ram_o,
  output logic [REG_IDX_W-1:0]        reg_idx_o,
  output logic [RAM_IDX_W-1:0]        ram_idx_o
);

  localparam logic [WA_W-1:0] REG_END   = WA_W'(REG_WORDS);
  localparam logic [WA_W-1:0] SUPV_END  = WA_W'(SUPV_WORDS);
  localparam logic [WA_W-1:0] MB_BASE   = WA_W'(MB_BASE_WORD);
  localparam logic [WA_W-1:0] MB_END    = WA_W'(MB_BASE_WORD + NUM_MB * WORDS_PER_MB);
  localparam logic [WA_W-1:0] MASK_BASE = WA_W'(MASK_BASE_WORD);
  localparam logic [WA_W-1:0] MASK_END  = WA_W'(MASK_BASE_WORD + NUM_MB);
  localparam logic [WA_W-1:0] IMPL_END  = WA_W'(IMPL_END_WORD);
  localparam int MB_SHIFT = $clog2(WORDS_PER_MB);

  logic [WA_W-1:0] mb_off, mk_off, limit;
  logic            supv, ro_all;

  assign mb_off = waddr_i - MB_BASE;
  assign mk_off = waddr_i - MASK_BASE;
  assign limit  = WA_W'(max_mb_i);

  always_comb begin
    cls_o     = CLS_UNIMP;
    is_reg_o  = 1'b0;
    is_ram_o  = 1'b0;
    supv      = 1'b0;
    reg_idx_o = '0;
    ram_idx_o = '0;
    if (waddr_i < REG_END) begin
      cls_o     = CLS_REG;
      is_reg_o  = 1'b1;
      reg_idx_o = REG_IDX_W'(waddr_i);
      supv      = waddr_i < SUPV_END;
    end else if (waddr_i < MB_BASE) begin
      cls_o = CLS_RSVD;
    end else if (waddr_i < MB_END) begin
      is_ram_o  = 1'b1;
      ram_idx_o = RAM_IDX_W'(mb_off);
      cls_o     = ((mb_off >> MB_SHIFT) <= limit) ? CLS_MB : CLS_GPRAM;
    end else if (waddr_i < MASK_BASE) begin
      cls_o = CLS_RSVD;
    end else if (waddr_i < MASK_END) begin
      is_ram_o  = 1'b1;
      ram_idx_o = RAM_IDX_W'(NUM_MB * WORDS_PER_MB) + RAM_IDX_W'(mk_off);
      cls_o     = (irmq_i && (mk_off <= limit)) ? CLS_MASK : CLS_GPRAM;
    end else if (waddr_i < IMPL_END) begin
      cls_o = CLS_RSVD;
    end
  end

  assign ro_all = &ro_mask_i[DATA_W*int'(reg_idx_o) +: DATA_W];

  assign err_o = (cls_o == CLS_RSVD) || (cls_o == CLS_UNIMP)
              || (supv && user_i)
              || (is_ram_o && lpm_i)
              || (write_i && is_reg_o && ro_all);

endmodule

// File: rtl/can_acc_regs.sv
module can_acc_regs
  import can_acc_pkg::*;
#(
  parameter int REG_WORDS  = 16,
  localparam int REG_IDX_W = $clog2(REG_WORDS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [REG_IDX_W-1:0]        idx_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [REG_WORDS*DATA_W-1:0] ro_mask_i,
  output logic [DATA_W-1:0]           rdata_o
);

  logic [REG_WORDS-1:0][DATA_W-1:0] regs_q;

  for (genvar w = 0; w < REG_WORDS; w++) begin : g_word
    logic [DATA_W-1:0] ro_w;
    assign ro_w = ro_mask_i[w*DATA_W +: DATA_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[w] <= '0;
      else if (we_i && idx_i == REG_IDX_W'(w))
        regs_q[w] <= (regs_q[w] & ro_w) | (wdata_i & ~ro_w);
    end

    AST_RO_BITS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && idx_i == REG_IDX_W'(w)) |=>
        ((regs_q[w] & $past(ro_w)) == ($past(regs_q[w]) & $past(ro_w)))); // R2
  end

  assign rdata_o = regs_q[idx_i];

  AST_REGS_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_q)); // R10

endmodule

// File: rtl/can_acc_ram.sv
module can_acc_ram
  import can_acc_pkg::*;
#(
  parameter int NUM_MB     = 16,
  localparam int RAM_WORDS = NUM_MB * (WORDS_PER_MB + 1),
  localparam int RAM_IDX_W = $clog2(RAM_WORDS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [RAM_IDX_W-1:0] idx_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o
);

  logic [RAM_WORDS-1:0][DATA_W-1:0] mem_q;

  for (genvar w = 0; w < RAM_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[w] <= '0;
      else if (we_i && idx_i == RAM_IDX_W'(w)) mem_q[w] <= wdata_i;
    end
  end

  assign rdata_o = (int'(idx_i) < RAM_WORDS) ? mem_q[idx_i] : '0;

  AST_RAM_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q)); // R10

endmodule

// File: rtl/can_acc_guard.sv
module can_acc_guard
  import can_acc_pkg::*;
#(
  parameter int WA_W       = 10,
  parameter int NUM_MB     = 16,
  parameter int REG_WORDS  = 16,
  parameter int SUPV_WORDS = 4,
  localparam int MB_IDX_W  = $clog2(NUM_MB),
  localparam int REG_IDX_W = $clog2(REG_WORDS),
  localparam int RAM_WORDS = NUM_MB * (WORDS_PER_MB + 1),
  localparam int RAM_IDX_W = $clog2(RAM_WORDS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  input  logic                        req_write_i,
  input  logic [WA_W-1:0]             req_waddr_i,
  input  logic [31:0]                 req_wdata_i,
  input  logic                        req_user_i,
  input  logic                        lpm_i,
  input  logic [MB_IDX_W-1:0]         max_mb_i,
  input  logic                        irmq_i,
  input  logic [REG_WORDS*32-1:0]     ro_mask_i,
  output logic                        rsp_valid_o,
  output logic                        rsp_err_o,
  output logic [31:0]                 rsp_rdata_o,
  output logic [2:0]                  rsp_class_o
);

  acc_class_e           dec_cls;
  logic                 dec_err, is_reg, is_ram, acc_ok;
  logic [REG_IDX_W-1:0] reg_idx;
  logic [RAM_IDX_W-1:0] ram_idx;
  logic [DATA_W-1:0]    reg_rd, ram_rd, rd_mux;

  can_acc_decode #(
    .WA_W(WA_W), .NUM_MB(NUM_MB), .REG_WORDS(REG_WORDS), .SUPV_WORDS(SUPV_WORDS)
  ) u_decode (
    .waddr_i  (req_waddr_i),
    .write_i  (req_write_i),
    .user_i   (req_user_i),
    .lpm_i    (lpm_i),
    .irmq_i   (irmq_i),
    .max_mb_i (max_mb_i),
    .ro_mask_i(ro_mask_i),
    .cls_o    (dec_cls),
    .err_o    (dec_err),
    .is_reg_o (is_reg),
    .is_ram_o (is_ram),
    .reg_idx_o(reg_idx),
    .ram_idx_o(ram_idx)
  );

  assign acc_ok = req_valid_i && !dec_err;

  can_acc_regs #(.REG_WORDS(REG_WORDS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (acc_ok && req_write_i && is_reg),
    .idx_i    (reg_idx),
    .wdata_i  (req_wdata_i),
    .ro_mask_i(ro_mask_i),
    .rdata_o  (reg_rd)
  );

  can_acc_ram #(.NUM_MB(NUM_MB)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (acc_ok && req_write_i && is_ram),
    .idx_i  (ram_idx),
    .wdata_i(req_wdata_i),
    .rdata_o(ram_rd)
  );

  always_comb begin
    rd_mux = '0;
    if (acc_ok && !req_write_i) begin
      if (is_reg)      rd_mux = reg_rd;
      else if (is_ram) rd_mux = ram_rd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_class_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i && dec_err;
      rsp_rdata_o <= rd_mux;
      rsp_class_o <= dec_cls;
    end
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R1
  AST_RSP_NONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R1
  AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_rdata_o == '0)); // R10
  AST_SUPV_USER_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_user_i && req_waddr_i < WA_W'(SUPV_WORDS)) |=> rsp_err_o); // R3
  AST_LPM_RAM_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && lpm_i) |=>
      !(rsp_valid_o && !rsp_err_o && rsp_class_o inside {3'd1, 3'd2, 3'd3})); // R7
  AST_HOLE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_class_o inside {3'd4, 3'd5}) |-> rsp_err_o); // R5 R6

endmodule

// File: tb/can_acc_guard_bench.sv
`timescale 1ns/1ps
module can_acc_guard_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [9:0]   req_waddr = '0;
  logic [31:0]  req_wdata = '0;
  logic         lpm = 1'b0, irmq = 1'b1;
  logic [3:0]   maxmb = 4'd15;
  logic [511:0] ro = '0;
  logic         rsp_valid, rsp_err;
  logic [31:0]  rsp_rdata;
  logic [2:0]   rsp_class;

  int n_chk = 0, n_fail = 0;
  logic [31:0] shadow [0:1023];

  can_acc_guard u_can_acc_guard (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_waddr_i(req_waddr),
    .req_wdata_i(req_wdata), .req_user_i(req_user),
    .lpm_i(lpm), .max_mb_i(maxmb), .irmq_i(irmq), .ro_mask_i(ro),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
    .rsp_rdata_o(rsp_rdata), .rsp_class_o(rsp_class)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int e_cls(int wa);
    if (wa < 16) return 0;
    if (wa < 'h20) return 4;
    if (wa < 'h60) return (((wa - 'h20) / 4) <= int'(maxmb)) ? 1 : 3;
    if (wa < 'h220) return 4;
    if (wa < 'h230) return (irmq && (wa - 'h220) <= int'(maxmb)) ? 2 : 3;
    if (wa < 'h278) return 4;
    return 5;
  endfunction

  function automatic bit e_err(int wa, bit wr, bit usr);
    int c = e_cls(wa);
    if (c >= 4) return 1'b1;
    if (c == 0 && wa < 4 && usr) return 1'b1;
    if (c != 0 && lpm) return 1'b1;
    if (wr && c == 0 && ro[wa*32 +: 32] == 32'hFFFF_FFFF) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string e_tag(int wa, bit wr, bit usr);
    int c = e_cls(wa);
    if (c == 5) return "R6";
    if (c == 4) return "R5";
    if (c == 0) begin
      if (wa < 4 && usr) return "R3";
      if (wr && ro[wa*32 +: 32] == 32'hFFFF_FFFF) return "R4";
      return "R2";
    end
    if (lpm) return "R7";
    if (wa < 'h60) return "R8";
    return "R9";
  endfunction

  task automatic acc(input bit wr, input int wa, input logic [31:0] wd, input bit usr);
    bit          x_err = e_err(wa, wr, usr);
    int          x_cls = e_cls(wa);
    string       tag   = e_tag(wa, wr, usr);
    logic [31:0] x_dat = (x_err || wr) ? 32'h0 : shadow[wa];
    req_valid = 1'b1; req_write = wr; req_waddr = wa[9:0];
    req_wdata = wd;   req_user  = usr;
    @(negedge clk);
    chk("R1", "rsp_valid", {31'b0, rsp_valid}, 32'd1);
    chk(tag, "rsp_err", {31'b0, rsp_err}, {31'b0, x_err});
    chk(tag, "rsp_class", {29'b0, rsp_class}, x_cls[31:0]);
    chk(x_err ? "R10" : tag, "rsp_rdata", rsp_rdata, x_dat);
    if (wr && !x_err) begin
      if (x_cls == 0) shadow[wa] = (shadow[wa] & ro[wa*32 +: 32]) | (wd & ~ro[wa*32 +: 32]);
      else            shadow[wa] = wd;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int mv [4] = '{0, 1, 7, 15};
    for (int i = 0; i < 1024; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1", "reset rsp_err", {31'b0, rsp_err}, 32'd0);
    chk("R1", "reset rsp_rdata", rsp_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill registers and RAM with address-tagged patterns
    for (int w = 0; w < 16; w++) acc(1'b1, w, 32'hA000_0000 | w, 1'b0);
    for (int w = 'h20; w < 'h60; w++) acc(1'b1, w, 32'h5000_0000 | (w * 4), 1'b0);
    for (int w = 'h220; w < 'h230; w++) acc(1'b1, w, 32'h6000_0000 | (w * 4), 1'b0);

    // R4: fully read-only word rejects write, partly read-only word merges
    ro[5*32 +: 32] = 32'hFFFF_FFFF;
    acc(1'b1, 5, 32'hDEAD_BEEF, 1'b0);
    acc(1'b0, 5, 32'h0, 1'b0);
    ro[5*32 +: 32] = 32'hFFFF_0000;
    acc(1'b1, 5, 32'h1234_5678, 1'b0);
    acc(1'b0, 5, 32'h0, 1'b0);
    chk("R2", "merged word", shadow[5], 32'hA000_5678);
    ro = '0;

    // R3: user write to supervisor word denied, user write elsewhere fine
    acc(1'b1, 2, 32'h1111_1111, 1'b1);
    acc(1'b0, 2, 32'h0, 1'b0);
    acc(1'b1, 6, 32'h2222_2222, 1'b1);
    acc(1'b0, 6, 32'h0, 1'b1);

    // R7: low-power blocks RAM, not registers
    lpm = 1'b1;
    acc(1'b1, 'h24, 32'h3333_3333, 1'b0);
    acc(1'b1, 'h225, 32'h3434_3434, 1'b0);
    acc(1'b1, 7, 32'h4444_4444, 1'b0);
    acc(1'b0, 7, 32'h0, 1'b0);
    lpm = 1'b0;
    acc(1'b0, 'h24, 32'h0, 1'b0);
    acc(1'b0, 'h225, 32'h0, 1'b0);

    // R10: writes into holes do nothing and return zero
    acc(1'b1, 'h80, 32'h5555_5555, 1'b0);
    acc(1'b1, 'h22F + 1, 32'h6666_6666, 1'b0);
    acc(1'b1, 'h300, 32'h7777_7777, 1'b0);
    // R8 R9: free RAM above the limit keeps written data
    maxmb = 4'd0; irmq = 1'b0;
    acc(1'b1, 'h5C, 32'h8888_8888, 1'b0);
    acc(1'b0, 'h5C, 32'h0, 1'b0);
    acc(1'b1, 'h220, 32'h9999_9999, 1'b0);
    acc(1'b0, 'h220, 32'h0, 1'b0);

    // full sweep of every word under every configuration
    for (int lp = 0; lp < 2; lp++)
      for (int ir = 0; ir < 2; ir++)
        for (int mi = 0; mi < 4; mi++)
          for (int us = 0; us < 2; us++) begin
            lpm = lp[0]; irmq = ir[0]; maxmb = mv[mi][3:0];
            for (int wa = 0; wa < 1024; wa++) acc(1'b0, wa, 32'h0, us[0]);
          end

    req_valid = 1'b0;
    @(negedge clk);
    chk("R1", "idle rsp_valid", {31'b0, rsp_valid}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule